// File: doc/BRIEF.md
# Serial configuration loader

This block pushes a stored configuration image into a downstream FPGA that is strapped for serial slave configuration. After a start pulse it reads the image through a byte-wide read port and checks an eight-byte header: a big-endian 32-bit magic word, then a big-endian 32-bit payload length. It then pulses the target's active-low program line and waits for the target to report that it is ready. After that it streams the payload out one bit per rising edge of a configuration clock, most significant bit first.

While streaming, the loader watches the target's active-low init/error line after every byte. Once the payload is out, it keeps clocking all-ones filler bytes until the target raises its configuration-complete line, then sends one more filler byte. A bounded wait guards that last phase. The outcome is reported on `ok` and a 3-bit `err_code`. Both are held until the next accepted start.

The memory port has a fixed latency and no back-pressure. A byte is read when `mem_rd` is high, and it appears on `mem_rdata` in the following cycle. The loader never issues a second read before it has used the first. All intervals are counted in system clock cycles, worked out from the clock frequency and time parameters.

Top module: `serial_cfg_loader`

## Requirements
- R1: Header bytes are read from addresses 0 to 7. Bytes 0–3 form the magic word and bytes 4–7 form the payload length, both most significant byte first. The payload is read from address 8 upward.
- R2: A magic word other than 0x53415231 ends the run with `err_code` 1. The program line stays high and no configuration clock edge is produced.
- R3: A length above 0x220000 ends the run with `err_code` 2, with no pin activity. Lengths at or below the limit proceed.
- R4: The program line is driven low for at least 250 ns and then released high. The init/error line is sampled at least 5 ms later. If it reads low, the run ends with `err_code` 3 and no configuration clock edge.
- R5: Each payload byte is sent MSB first, with one configuration clock rising edge per bit. The data line only changes while the configuration clock is low.
- R6: The program line is high at every configuration clock rising edge. When idle, the program line is high and both the configuration clock and data lines are low.
- R7: If the init/error line reads low at the end of a payload byte, the run ends with `err_code` 4 and no further bits are sent.
- R8: After the payload, 0xFF bytes are sent until the complete line is seen high. Then exactly one more 0xFF byte is sent, `ok` goes to 1 and `err_code` stays 0.
- R9: If the complete line is not high within 100 ms of the end of the payload, the run ends with `err_code` 5.
- R10: `ok` and `err_code` are held until the next start. An accepted start clears both. A start while `busy` is high has no effect on the run in progress.
- R11: A zero payload length skips streaming and goes straight to the filler/complete phase.
- R12: After reset, `busy`, `ok`, `err_code`, `mem_rd`, the configuration clock and the data line are all 0, and the program line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a load (accepted only when not busy) |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load completed successfully |
| err_code | output | 3 | 0 none, 1 bad magic, 2 too long, 3 not ready, 4 error mid-stream, 5 complete timeout |
| mem_rd | output | 1 | Image read strobe |
| mem_addr | output | ADDR_W | Image byte address |
| mem_rdata | input | 8 | Image byte, valid the cycle after `mem_rd` |
| cfg_clk | output | 1 | Configuration clock to target |
| cfg_data | output | 1 | Configuration serial data to target |
| cfg_prog_n | output | 1 | Program request to target, active low |
| cfg_init_n | input | 1 | Target ready / error status, low means not ready or fault |
| cfg_done | input | 1 | Target configuration complete |

## Verification
The loader is run against a set of images, and each one separates a different path:

- **Correct images.** These use distinct payloads such as 0xA5 0x3C 0x01 and 0x81 0x7E, with the complete line rising either at the end of the payload or only after several fillers. Together they tell bit order, byte order and the filler count apart.
- **Header errors.** A byte-swapped magic word and a length whose bytes would read as a small value under the wrong byte order show whether the header is assembled big-endian. An over-limit length and a wrong magic word check the aborts that happen with no pin activity.
- **Target faults.** A target that never becomes ready, one that drops its status line in the middle of a byte, and one that never completes check that each fault maps to its own code and that streaming stops where it should.
- **Zero length.** A zero-length image checks the path that skips streaming.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_MAGIC   = 3'd1,
    ERR_LENGTH  = 3'd2,
    ERR_INIT    = 3'd3,
    ERR_STREAM  = 3'd4,
    ERR_TIMEOUT = 3'd5
  } scl_err_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR_ADDR,
    ST_HDR_DATA,
    ST_CHECK,
    ST_PROG_LOW,
    ST_INIT_WAIT,
    ST_FETCH,
    ST_LOAD,
    ST_SHIFT,
    ST_DONE_CHK,
    ST_FILL,
    ST_TAIL
  } scl_state_e;

  localparam int          HDR_BYTES = 8;
  localparam logic [7:0]  FILL_BYTE = 8'hFF;

endpackage

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TMR_W-1:0] value_i,
  output logic             expired_o
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= value_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // the load cycle never reports expiry, so a stale zero cannot leak through
  assign expired_o = !load_i && (cnt_q == '0);

endmodule

// File: rtl/scl_bit_shifter.sv
module scl_bit_shifter #(
  parameter int HALF_CYC = 11,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              ser_clk_o,
  output logic              ser_data_o,
  output logic              done_o
);

  localparam int CNT_W = $clog2(HALF_CYC + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] RELOAD   = CNT_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              phase_q;
  logic              active_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      bit_q    <= '0;
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        sh_q     <= byte_i;
        bit_q    <= '0;
        phase_q  <= 1'b0;
        cnt_q    <= RELOAD;
      end else if (active_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (!phase_q) begin
          phase_q <= 1'b1;
          cnt_q   <= RELOAD;
        end else if (bit_q == LAST_BIT) begin
          phase_q  <= 1'b0;
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          bit_q   <= bit_q + 1'b1;
          sh_q    <= {sh_q[DATA_W-2:0], 1'b0};
          phase_q <= 1'b0;
          cnt_q   <= RELOAD;
        end
      end
    end
  end

  assign ser_clk_o  = active_q && phase_q;
  assign ser_data_o = active_q && sh_q[DATA_W-1];
  assign done_o     = done_q;

  assert_data_steady_R5 : assert property (@(posedge clk) disable iff (rst)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));

  assert_byte_end_low_R5 : assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!ser_clk_o && !ser_data_o));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import scl_pkg::*;
#(
  parameter int          CLK_HZ      = 125_000_000,
  parameter int          CFG_CLK_HZ  = 6_000_000,
  parameter int          PROG_NS     = 250,
  parameter int          INIT_US     = 5_000,
  parameter int          DONE_US     = 100_000,
  parameter int          ADDR_W      = 24,
  parameter int          TMR_W       = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] MAGIC_WORD  = 32'h5341_5231,
  parameter logic [31:0] MAX_LEN     = 32'h0022_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              ok,
  output logic [2:0]        err_code,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              cfg_clk,
  output logic              cfg_data,
  output logic              cfg_prog_n,
  input  logic              cfg_init_n,
  input  logic              cfg_done
);

  localparam int     HALF_RAW = (CLK_HZ + 2 * CFG_CLK_HZ - 1) / (2 * CFG_CLK_HZ);
  localparam int     HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam longint CLK_L    = longint'(CLK_HZ);
  localparam longint PROG_L   = (CLK_L * PROG_NS + 64'sd999_999_999) / 64'sd1_000_000_000;
  localparam longint INIT_L   = CLK_L * INIT_US / 64'sd1_000_000;
  localparam longint DONE_L   = CLK_L * DONE_US / 64'sd1_000_000;
  localparam logic [TMR_W-1:0] PROG_CYC = TMR_W'(PROG_L);
  localparam logic [TMR_W-1:0] INIT_CYC = TMR_W'(INIT_L);
  localparam logic [TMR_W-1:0] DONE_CYC = TMR_W'(DONE_L);
  localparam logic [2:0]       HDR_LAST = 3'(HDR_BYTES - 1);

  scl_state_e        state_q;
  scl_err_e          err_q;
  logic              busy_q, ok_q, prog_n_q;
  logic [2:0]        hdr_idx_q;
  logic [63:0]       hdr_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [31:0]       remain_q;
  logic              tmr_load_q, tmr_exp;
  logic [TMR_W-1:0]  tmr_val_q;
  logic              sh_start_q, sh_done;
  logic [7:0]        sh_byte_q;
  logic [SYNC_STAGES-1:0] init_sync_q, done_sync_q;
  logic              init_ok_s, done_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_sync_q <= '0;
      done_sync_q <= '0;
    end else begin
      init_sync_q <= {init_sync_q[SYNC_STAGES-2:0], cfg_init_n};
      done_sync_q <= {done_sync_q[SYNC_STAGES-2:0], cfg_done};
    end
  end
  assign init_ok_s = init_sync_q[SYNC_STAGES-1];
  assign done_s    = done_sync_q[SYNC_STAGES-1];

  scl_timer #(.TMR_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load_q),
    .value_i   (tmr_val_q),
    .expired_o (tmr_exp)
  );

  scl_bit_shifter #(.HALF_CYC(HALF_CYC), .DATA_W(8)) u_shifter (
    .clk        (clk),
    .rst        (rst),
    .start_i    (sh_start_q),
    .byte_i     (sh_byte_q),
    .ser_clk_o  (cfg_clk),
    .ser_data_o (cfg_data),
    .done_o     (sh_done)
  );

  // the read is combinational from state; data is consumed one state later
  assign mem_rd   = (state_q == ST_HDR_ADDR) || (state_q == ST_FETCH);
  assign mem_addr = (state_q == ST_HDR_ADDR) ? ADDR_W'(hdr_idx_q) : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      err_q      <= ERR_NONE;
      busy_q     <= 1'b0;
      ok_q       <= 1'b0;
      prog_n_q   <= 1'b1;
      hdr_idx_q  <= '0;
      hdr_q      <= '0;
      ptr_q      <= '0;
      remain_q   <= '0;
      tmr_load_q <= 1'b0;
      tmr_val_q  <= '0;
      sh_start_q <= 1'b0;
      sh_byte_q  <= '0;
    end else begin
      tmr_load_q <= 1'b0;
      sh_start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          busy_q    <= 1'b1;
          ok_q      <= 1'b0;
          err_q     <= ERR_NONE;
          hdr_idx_q <= '0;
          state_q   <= ST_HDR_ADDR;
        end
        ST_HDR_ADDR: state_q <= ST_HDR_DATA;
        ST_HDR_DATA: begin
          hdr_q <= {hdr_q[55:0], mem_rdata};
          if (hdr_idx_q == HDR_LAST) begin
            state_q <= ST_CHECK;
          end else begin
            hdr_idx_q <= hdr_idx_q + 1'b1;
            state_q   <= ST_HDR_ADDR;
          end
        end
        ST_CHECK: begin
          ptr_q    <= ADDR_W'(HDR_BYTES);
          remain_q <= hdr_q[31:0];
          if (hdr_q[63:32] != MAGIC_WORD) begin
            err_q   <= ERR_MAGIC;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (hdr_q[31:0] > MAX_LEN) begin
            err_q   <= ERR_LENGTH;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            prog_n_q   <= 1'b0;
            tmr_load_q <= 1'b1;
            tmr_val_q  <= PROG_CYC;
            state_q    <= ST_PROG_LOW;
          end
        end
        ST_PROG_LOW: if (tmr_exp) begin
          prog_n_q   <= 1'b1;
          tmr_load_q <= 1'b1;
          tmr_val_q  <= INIT_CYC;
          state_q    <= ST_INIT_WAIT;
        end
        ST_INIT_WAIT: if (tmr_exp) begin
          if (!init_ok_s) begin
            err_q   <= ERR_INIT;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (remain_q == '0) begin
            tmr_load_q <= 1'b1;
            tmr_val_q  <= DONE_CYC;
            state_q    <= ST_DONE_CHK;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          sh_start_q <= 1'b1;
          sh_byte_q  <= mem_rdata;
          ptr_q      <= ptr_q + 1'b1;
          remain_q   <= remain_q - 1'b1;
          state_q    <= ST_SHIFT;
        end
        ST_SHIFT: if (sh_done) begin
          if (!init_ok_s) begin
            err_q   <= ERR_STREAM;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (remain_q != '0) begin
            state_q <= ST_FETCH;
          end else begin
            tmr_load_q <= 1'b1;
            tmr_val_q  <= DONE_CYC;
            state_q    <= ST_DONE_CHK;
          end
        end
        ST_DONE_CHK: begin
          if (done_s) begin
            sh_start_q <= 1'b1;
            sh_byte_q  <= FILL_BYTE;
            state_q    <= ST_TAIL;
          end else if (tmr_exp) begin
            err_q   <= ERR_TIMEOUT;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            sh_start_q <= 1'b1;
            sh_byte_q  <= FILL_BYTE;
            state_q    <= ST_FILL;
          end
        end
        ST_FILL: if (sh_done) state_q <= ST_DONE_CHK;
        ST_TAIL: if (sh_done) begin
          ok_q    <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign ok         = ok_q;
  assign err_code   = err_q;
  assign cfg_prog_n = prog_n_q;

  assert_pins_parked_R6 : assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!cfg_clk && !cfg_data && cfg_prog_n));

  assert_prog_high_on_edge_R6 : assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_clk) |-> cfg_prog_n);

  assert_result_held_R10 : assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(err_code) && $stable(ok)));

  assert_read_in_run_R1 : assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  assert_ok_clean_R8 : assert property (@(posedge clk) disable iff (rst)
    ok |-> (err_code == 3'd0));

  assert_header_quiet_R2 : assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HDR_DATA) |-> (cfg_prog_n && !cfg_clk));

endmodule

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;

  localparam int NEVER    = 1_000_000;
  localparam int INIT_MIN = 250;  // 2 us at 125 MHz
  localparam int DONE_MIN = 500;  // 4 us at 125 MHz
  localparam logic [31:0] MAGIC = 32'h5341_5231;

  typedef struct packed {
    logic [31:0] magic;
    logic [31:0] len;
    logic [31:0] pay;
    logic        init_ok;
    logic [7:0]  drop_edge;
    logic [15:0] done_edge;
    logic [2:0]  exp_err;
    logic [15:0] exp_edges;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{MAGIC,         32'd3, 32'hA53C0100, 1'b1, 8'd0,  16'd24,    3'd0, 16'd32,    4'd5},  // R5 done at payload end
    '{MAGIC,         32'd2, 32'h817E0000, 1'b1, 8'd0,  16'd40,    3'd0, 16'd48,    4'd8},  // R8 three fillers + tail
    '{MAGIC,         32'd0, 32'h00000000, 1'b1, 8'd0,  16'd0,     3'd0, 16'd8,     4'd11}, // R11 zero length
    '{32'h53415230,  32'd2, 32'h11220000, 1'b1, 8'd0,  16'hFFFF,  3'd1, 16'd0,     4'd2},  // R2 wrong magic
    '{32'h31524153,  32'd2, 32'h11220000, 1'b1, 8'd0,  16'hFFFF,  3'd1, 16'd0,     4'd1},  // R1 swapped magic
    '{MAGIC,         32'd2, 32'h11220000, 1'b0, 8'd0,  16'hFFFF,  3'd3, 16'd0,     4'd4},  // R4 never ready
    '{MAGIC,         32'd3, 32'hFFFFFF00, 1'b1, 8'd12, 16'hFFFF,  3'd4, 16'd16,    4'd7},  // R7 drop in byte 2
    '{MAGIC,         32'd1, 32'h5A000000, 1'b1, 8'd0,  16'hFFFF,  3'd5, 16'hFFFF,  4'd9},  // R9 never complete
    '{MAGIC,   32'h00220001, 32'h0,       1'b1, 8'd0,  16'hFFFF,  3'd2, 16'd0,     4'd3},  // R3 one over limit
    '{MAGIC,   32'h01000000, 32'h0,       1'b1, 8'd0,  16'hFFFF,  3'd2, 16'd0,     4'd1}   // R1 length byte order
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, ok, mem_rd, cfg_clk, cfg_data, cfg_prog_n;
  logic [2:0]  err_code;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        cfg_init_n = 1'b1;
  logic        cfg_done = 1'b0;

  always #4 clk = ~clk;

  serial_cfg_loader #(
    .CFG_CLK_HZ (31_250_000),
    .INIT_US    (2),
    .DONE_US    (4)
  ) i_serial_cfg_loader (
    .clk (clk), .rst (rst), .start (start), .busy (busy), .ok (ok),
    .err_code (err_code), .mem_rd (mem_rd), .mem_addr (mem_addr),
    .mem_rdata (mem_rdata), .cfg_clk (cfg_clk), .cfg_data (cfg_data),
    .cfg_prog_n (cfg_prog_n), .cfg_init_n (cfg_init_n), .cfg_done (cfg_done)
  );

  logic [7:0] mem [0:63];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];

  int checks = 0;
  int fails  = 0;
  bit init_ok = 1'b1;
  int drop_edge = 0;
  int done_edge = NEVER;
  int run_len = 0;
  bit clr_mon = 1'b0;
  int edges, prog_low, gap, tail_cyc, pin_bad;
  bit prog_seen;
  logic prev_clk = 1'b0;
  logic [7:0] cap [0:31];

  // pin monitor: counts target clock edges and captures bits at each rise
  always @(negedge clk) begin
    if (clr_mon) begin
      edges = 0; prog_low = 0; gap = 0; tail_cyc = 0; pin_bad = 0; prog_seen = 1'b0;
      for (int k = 0; k < 32; k++) cap[k] = 8'h00;
    end else begin
      if (cfg_clk && !prev_clk) begin
        if (edges / 8 < 32) cap[edges / 8] = {cap[edges / 8][6:0], cfg_data};
        if (!cfg_prog_n) pin_bad++;
        edges++;
      end
      if (!cfg_prog_n) begin
        prog_low++;
        prog_seen = 1'b1;
      end else if (prog_seen && edges == 0) begin
        gap++;
      end
      if (busy && edges >= run_len * 8 && edges > 0) tail_cyc++;
    end
    prev_clk   = cfg_clk;
    cfg_done   = (edges >= done_edge);
    cfg_init_n = init_ok && !(drop_edge != 0 && edges >= drop_edge);
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input longint act, input longint lo);
    checks++;
    if (act < lo) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lo);
    end
  endtask

  logic [2:0] first_err;
  logic       first_ok, first_busy;

  task automatic run_vec(input vec_t v, input int restart_at);
    int n;
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      mem[k]     = v.magic[31 - 8 * k -: 8];
      mem[4 + k] = v.len[31 - 8 * k -: 8];
      mem[8 + k] = v.pay[31 - 8 * k -: 8];
    end
    init_ok   = v.init_ok;
    drop_edge = int'(v.drop_edge);
    done_edge = (v.done_edge == 16'hFFFF) ? NEVER : int'(v.done_edge);
    run_len   = (v.len > 32'd1000) ? 1000 : int'(v.len);
    clr_mon   = 1'b1;
    @(negedge clk);
    @(posedge clk);
    clr_mon = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    first_err  = err_code;
    first_ok   = ok;
    first_busy = busy;
    n = 0;
    while (busy && n < 6000) begin
      @(negedge clk);
      n++;
      start = (n == restart_at);
    end
    start = 1'b0;
    chk_ge("R10", "run finished within limit (cycles left)", 6000 - n, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "busy", busy, 0);
    chk("R12", "ok", ok, 0);
    chk("R12", "err_code", err_code, 0);
    chk("R12", "mem_rd", mem_rd, 0);
    chk("R12", "clk/data", {cfg_clk, cfg_data}, 0);
    chk("R12", "prog_n", cfg_prog_n, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      int pay_bad, fill_bad;
      v   = VECS[i];
      tag = $sformatf("R%0d", v.req);
      run_vec(v, 0);
      chk(tag, $sformatf("vec %0d err_code", i), err_code, v.exp_err);
      chk(tag, $sformatf("vec %0d ok", i), ok, (v.exp_err == 3'd0) ? 1 : 0);
      if (v.exp_edges != 16'hFFFF)
        chk(tag, $sformatf("vec %0d clock edges", i), edges, v.exp_edges);
      pay_bad = 0;
      fill_bad = 0;
      for (int b = 0; b < edges / 8 && b < 32; b++) begin
        if (b < run_len) begin
          if (b < 4 && cap[b] != v.pay[31 - 8 * b -: 8]) pay_bad++;
        end else if (cap[b] != 8'hFF) begin
          fill_bad++;
        end
      end
      chk("R5", $sformatf("vec %0d payload bytes wrong", i), pay_bad, 0);
      chk("R8", $sformatf("vec %0d filler bytes wrong", i), fill_bad, 0);
      chk("R6", $sformatf("vec %0d edges with prog low", i), pin_bad, 0);
      chk("R6", $sformatf("vec %0d idle pins", i), {cfg_clk, cfg_data, cfg_prog_n}, 3'b001);
      if (v.exp_err == 3'd1 || v.exp_err == 3'd2)
        chk("R2", $sformatf("vec %0d prog low cycles (R3 too)", i), prog_low, 0);
      if (i == 0) begin
        chk_ge("R4", "prog low ns", prog_low * 8, 250);
        chk_ge("R4", "ready wait cycles", gap, INIT_MIN);
      end
      if (v.exp_err == 3'd5) begin
        chk_ge("R9", "cycles after payload", tail_cyc, DONE_MIN);
        chk("R9", "whole bytes only", edges % 8, 0);
      end
    end

    // R10: result held while idle
    repeat (40) @(negedge clk);
    chk("R10", "err held idle", err_code, 2);
    chk("R10", "ok held idle", ok, 0);

    // R10: accepted start clears result; a second start mid-run is ignored
    run_vec(VECS[0], 60);
    chk("R10", "err cleared at start", first_err, 0);
    chk("R10", "ok cleared at start", first_ok, 0);
    chk("R10", "busy after start", first_busy, 1);
    chk("R10", "restart ignored: err", err_code, 0);
    chk("R10", "restart ignored: ok", ok, 1);
    chk("R10", "restart ignored: edges", edges, 32);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog: actual=150000 expected<150000 cycles");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule